// File: doc/BRIEF.md
# Dual-Compare Watchdog Counter

This block is a free-running up-counter with two compare channels. It is meant for supervising software. Each channel compares the running count against its own programmable value. When the two are equal on a clock edge while counting is on, the channel can take any mix of three actions, chosen per channel in a match-action register:
- latch a sticky status flag,
- force the counter back to zero,
- switch counting off.

Channel 0 is the early warning. Its status flag, gated by an interrupt-enable bit, drives the interrupt output. Channel 1 is the last line of defence. Every equality seen on channel 1 while counting produces a one-cycle reset-request pulse, whatever its action bits say. In normal watchdog use, channel 0 has its clear and stop actions off, so the count carries on past the warning value to the reset value. Software keeps the system alive by clearing status and re-arming before channel 1 is reached.

Access is through a simple single-cycle register port. Writes take effect on the clock edge where the write enable is high. Reads return data combinationally for the address presented.

Top module: `wdt_dual_match`

## Requirements
- R1: After the active-low asynchronous reset, every readable register reads 0, and both `irq_o` and `rst_req_o` are 0.
- R2: While the run bit (bit 0 at address 0) is 1, the count (read-only at address 1) rises by one on each clock. While the run bit is 0, the count holds.
- R3: Address 2 holds six action bits:
  - for channel 0: bit 0 is flag, bit 1 is clear, bit 2 is stop;
  - for channel 1: bit 3 is flag, bit 4 is clear, bit 5 is stop.
  
  With its flag bit set, a channel's equality while running sets its status bit at address 5 (bit 0 for channel 0, bit 1 for channel 1). That status bit stays set afterwards.
- R4: Writing 1 to a status bit at address 5 clears it. Writing 0 leaves it unchanged.
- R5: A channel equality while running with that channel's clear bit set loads 0 into the count on that edge, instead of incrementing.
- R6: A channel equality while running with that channel's stop bit set clears the run bit, and the count does not advance on that edge. With clear also set, the count becomes 0 and then holds at 0.
- R7: `irq_o` equals status bit 0 AND the interrupt-enable bit (bit 0 at address 6).
- R8: `rst_req_o` is high for exactly the cycle after an edge where the count equals the channel 1 compare value (address 4) while running. This is independent of the channel 1 flag bit.
- R9: While the run bit is 0, an equal compare value sets no status bit and raises no reset request.
- R10: The register map is:
  - address 0: run bit;
  - address 1: count, read-only;
  - address 2: action bits;
  - address 3: channel 0 compare;
  - address 4: channel 1 compare;
  - address 5: status;
  - address 6: interrupt enable.
  
  Address 7 and all bits above each field's width read 0, and writes to them are ignored.
- R11: A software write to address 0 on the same edge as a stop action takes priority: the run bit takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `we_i`, `addr_i` and `wdata_i` are stable around each rising edge. They also assume that a write to the run register is the only outside influence on the run bit; the stop-action property exempts exactly that case. The bench changes its inputs only on falling edges. It restarts the counter between scenarios with the asynchronous reset, because software cannot load the count. That keeps every compare value reachable within a few cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_CH   = 2;
  localparam int unsigned ACT_W  = 3;
  localparam int unsigned MC_W   = ACT_W * N_CH;

  localparam logic [ADDR_W-1:0] A_RUN  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ACT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP0 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP1 = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd6;

  typedef struct packed {
    logic stop;
    logic clr;
    logic flag;
  } ch_act_t;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (run_i) begin
      if (clr_i)      cnt_q <= '0;
      else if (!hold_i) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !clr_i && !hold_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_o));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && clr_i |=> cnt_o == '0);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && hold_i && !clr_i |=> $stable(cnt_o));
endmodule

// File: rtl/wdt_match.sv
module wdt_match
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                       run_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp_i,
  input  ch_act_t [N_CH-1:0]         act_i,
  output logic [N_CH-1:0]            flag_o,
  output logic                       clr_o,
  output logic                       stop_o,
  output logic                       last_hit_o
);
  logic [N_CH-1:0] hit, clr_v, stop_v;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign hit[g]    = run_i && (cnt_i == cmp_i[g]);
    assign flag_o[g] = hit[g] & act_i[g].flag;
    assign clr_v[g]  = hit[g] & act_i[g].clr;
    assign stop_v[g] = hit[g] & act_i[g].stop;
  end

  assign clr_o      = |clr_v;
  assign stop_o     = |stop_v;
  assign last_hit_o = hit[N_CH-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [CNT_W-1:0]           wdata_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [N_CH-1:0]            flag_i,
  input  logic                       stop_i,
  output logic                       run_o,
  output ch_act_t [N_CH-1:0]         act_o,
  output logic [N_CH-1:0][CNT_W-1:0] cmp_o,
  output logic [N_CH-1:0]            stat_o,
  output logic                       ien_o,
  output logic [CNT_W-1:0]           rdata_o
);
  logic                       run_q, ien_q;
  logic [MC_W-1:0]            act_q;
  logic [N_CH-1:0][CNT_W-1:0] cmp_q;
  logic [N_CH-1:0]            stat_q, w1c;
  logic                       wr_run;

  assign wr_run = we_i && (addr_i == A_RUN);
  assign w1c    = (we_i && addr_i == A_STAT) ? wdata_i[N_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
      act_q  <= '0;
      cmp_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_run)      run_q <= wdata_i[0];
      else if (stop_i) run_q <= 1'b0;
      if (we_i && addr_i == A_IEN)  ien_q    <= wdata_i[0];
      if (we_i && addr_i == A_ACT)  act_q    <= wdata_i[MC_W-1:0];
      if (we_i && addr_i == A_CMP0) cmp_q[0] <= wdata_i;
      if (we_i && addr_i == A_CMP1) cmp_q[1] <= wdata_i;
      stat_q <= (stat_q & ~w1c) | flag_i;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_act
    assign act_o[g] = act_q[g*ACT_W +: ACT_W];

    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[g] && !w1c[g] |=> stat_o[g]);

    p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      w1c[g] && !flag_i[g] |=> !stat_o[g]);
  end

  assign run_o  = run_q;
  assign ien_o  = ien_q;
  assign cmp_o  = cmp_q;
  assign stat_o = stat_q;

  always_comb begin
    unique case (addr_i)
      A_RUN:   rdata_o = CNT_W'(run_q);
      A_CNT:   rdata_o = cnt_i;
      A_ACT:   rdata_o = CNT_W'(act_q);
      A_CMP0:  rdata_o = cmp_q[0];
      A_CMP1:  rdata_o = cmp_q[1];
      A_STAT:  rdata_o = CNT_W'(stat_q);
      A_IEN:   rdata_o = CNT_W'(ien_q);
      default: rdata_o = '0;
    endcase
  end

  p_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !wr_run |=> !run_o);

  p_sw_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_run |=> run_o == $past(wdata_i[0]));
endmodule

// File: rtl/wdt_dual_match.sv
module wdt_dual_match
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic                       run, clr, stop, last_hit, ien;
  logic [CNT_W-1:0]           cnt;
  logic [N_CH-1:0][CNT_W-1:0] cmp;
  logic [N_CH-1:0]            flag, stat;
  ch_act_t [N_CH-1:0]         act;
  logic                       rst_req_q;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cnt_i(cnt), .flag_i(flag), .stop_i(stop),
    .run_o(run), .act_o(act), .cmp_o(cmp), .stat_o(stat),
    .ien_o(ien), .rdata_o(rdata_o)
  );

  wdt_match #(.CNT_W(CNT_W)) u_match (
    .run_i(run), .cnt_i(cnt), .cmp_i(cmp), .act_i(act),
    .flag_o(flag), .clr_o(clr), .stop_o(stop), .last_hit_o(last_hit)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clr_i(clr),
    .hold_i(stop), .cnt_o(cnt)
  );

  // reset request: registered, ignores channel flag enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= last_hit;
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = stat[0] & ien;

  p_rst_req_needs_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !rst_req_o);
endmodule

// File: tb/wdt_dual_match_tb.sv
`timescale 1ns/1ps
module wdt_dual_match_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  wdt_dual_match u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  // behavioural reference
  logic [31:0] m_cnt, m_c0, m_c1;
  logic [5:0]  m_act;
  logic [1:0]  m_st;
  logic        m_run, m_ie, m_rr;

  task automatic model_reset();
    m_cnt = 0; m_c0 = 0; m_c1 = 0; m_act = 0; m_st = 0;
    m_run = 0; m_ie = 0; m_rr = 0;
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_run};
      3'd1: return m_cnt;
      3'd2: return {26'd0, m_act};
      3'd3: return m_c0;
      3'd4: return m_c1;
      3'd5: return {30'd0, m_st};
      3'd6: return {31'd0, m_ie};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_step();
    logic e0, e1, zap, halt, nrun;
    logic [1:0] setb;
    e0   = m_run && (m_cnt == m_c0);
    e1   = m_run && (m_cnt == m_c1);
    zap  = (e0 && m_act[1]) || (e1 && m_act[4]);
    halt = (e0 && m_act[2]) || (e1 && m_act[5]);
    setb = {e1 && m_act[3], e0 && m_act[0]};
    nrun = m_run && !halt;
    if (m_run) begin
      if (zap)        m_cnt = 0;
      else if (!halt) m_cnt = m_cnt + 1;
    end
    if (we) begin
      case (addr)
        3'd0: nrun  = wdata[0];
        3'd2: m_act = wdata[5:0];
        3'd3: m_c0  = wdata;
        3'd4: m_c1  = wdata;
        3'd5: m_st  = m_st & ~wdata[1:0];
        3'd6: m_ie  = wdata[0];
        default: ;
      endcase
    end
    m_st  = m_st | setb;
    m_run = nrun;
    m_rr  = e1;
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    check(rdata === m_read(addr), "R10 read vs model", rdata, m_read(addr));
    check(irq === (m_st[0] & m_ie), "R7 irq vs model", {31'd0, irq}, {31'd0, m_st[0] & m_ie});
    check(rst_req === m_rr, "R8 rst_req vs model", {31'd0, rst_req}, {31'd0, m_rr});
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check(rdata === exp, req, rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    we = 1'b0;
    rst_ni = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    for (int a = 0; a < 8; a++) rd_check(3'(a), 32'd0, "R1 reset value");
    check(irq === 1'b0 && rst_req === 1'b0, "R1 outputs low", {30'd0, irq, rst_req}, 32'd0);

    // R10: reserved bits, read-only count, unused address
    wr(3'd2, 32'hFFFF_FFFF); rd_check(3'd2, 32'h3F, "R10 action width");
    wr(3'd0, 32'hFFFF_FFFE); rd_check(3'd0, 32'd0, "R10 run reserved");
    wr(3'd6, 32'hFFFF_FFFE); rd_check(3'd6, 32'd0, "R10 ien reserved");
    wr(3'd1, 32'h0000_1234); rd_check(3'd1, 32'd0, "R10 count read-only");
    wr(3'd7, 32'hFFFF_FFFF); rd_check(3'd7, 32'd0, "R10 address 7");

    // R2: count and hold
    do_reset();
    wr(3'd4, 32'd1000);
    wr(3'd0, 32'd1);
    ticks(10); rd_check(3'd1, 32'd10, "R2 count rises");
    wr(3'd0, 32'd0);
    ticks(3); rd_check(3'd1, 32'd11, "R2 count holds");

    // R3 R7 R4: flag channel 0, interrupt gating, write-one-to-clear
    do_reset();
    wr(3'd4, 32'd1000); wr(3'd3, 32'd5); wr(3'd2, 32'd1); wr(3'd6, 32'd1);
    wr(3'd0, 32'd1);
    ticks(5); rd_check(3'd5, 32'd0, "R3 before compare");
    tick();   rd_check(3'd5, 32'd1, "R3 status set");
    check(irq === 1'b1, "R7 irq on", {31'd0, irq}, 32'd1);
    ticks(3); rd_check(3'd5, 32'd1, "R3 status sticky");
    wr(3'd6, 32'd0);
    check(irq === 1'b0, "R7 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'd1);
    wr(3'd5, 32'd0); rd_check(3'd5, 32'd1, "R4 write zero keeps");
    wr(3'd5, 32'd1); rd_check(3'd5, 32'd0, "R4 write one clears");
    check(irq === 1'b0, "R7 irq after clear", {31'd0, irq}, 32'd0);

    // R5: clear action, channel 0 and channel 1
    do_reset();
    wr(3'd4, 32'd1000); wr(3'd3, 32'd3); wr(3'd2, 32'd2);
    wr(3'd0, 32'd1);
    ticks(3); rd_check(3'd1, 32'd3, "R5 reach compare");
    tick();   rd_check(3'd1, 32'd0, "R5 ch0 clear");
    ticks(3); rd_check(3'd1, 32'd3, "R5 recount");
    rd_check(3'd5, 32'd0, "R3 no flag when disabled");
    do_reset();
    wr(3'd3, 32'd1000); wr(3'd4, 32'd2); wr(3'd2, 32'h10);
    wr(3'd0, 32'd1);
    ticks(2); rd_check(3'd1, 32'd2, "R5 ch1 reach");
    tick();   rd_check(3'd1, 32'd0, "R5 ch1 clear");

    // R6 R9: stop action, then no further events while stopped
    do_reset();
    wr(3'd4, 32'd1000); wr(3'd3, 32'd5); wr(3'd2, 32'd5);
    wr(3'd0, 32'd1);
    ticks(8);
    rd_check(3'd1, 32'd5, "R6 count frozen at compare");
    rd_check(3'd0, 32'd0, "R6 run cleared");
    rd_check(3'd5, 32'd1, "R3 flag with stop");
    wr(3'd5, 32'd1);
    ticks(4); rd_check(3'd5, 32'd0, "R9 no flag while stopped");
    do_reset();
    wr(3'd4, 32'd1000); wr(3'd3, 32'd5); wr(3'd2, 32'd6);
    wr(3'd0, 32'd1);
    ticks(8);
    rd_check(3'd1, 32'd0, "R6 clear and stop holds zero");
    rd_check(3'd0, 32'd0, "R6 run cleared with clear");
    do_reset();
    wr(3'd3, 32'd1000); wr(3'd4, 32'd3); wr(3'd2, 32'h20);
    wr(3'd0, 32'd1);
    ticks(6);
    rd_check(3'd1, 32'd3, "R6 ch1 stop count");
    rd_check(3'd0, 32'd0, "R6 ch1 stop run");
    check(rst_req === 1'b0, "R9 no request while stopped", {31'd0, rst_req}, 32'd0);

    // R8: reset request pulse, independent of flag bit
    do_reset();
    wr(3'd4, 32'd4); wr(3'd3, 32'd1000);
    wr(3'd0, 32'd1);
    ticks(4); check(rst_req === 1'b0, "R8 before compare", {31'd0, rst_req}, 32'd0);
    tick();   check(rst_req === 1'b1, "R8 pulse", {31'd0, rst_req}, 32'd1);
    tick();   check(rst_req === 1'b0, "R8 single cycle", {31'd0, rst_req}, 32'd0);
    rd_check(3'd5, 32'd0, "R8 no status without flag");

    // R11: software run write beats stop action
    do_reset();
    wr(3'd4, 32'd1000); wr(3'd3, 32'd5); wr(3'd2, 32'd4);
    wr(3'd0, 32'd1);
    ticks(5);
    wr(3'd0, 32'd1);
    rd_check(3'd0, 32'd1, "R11 write wins");
    rd_check(3'd1, 32'd5, "R11 count held on stop edge");
    tick();
    rd_check(3'd0, 32'd0, "R11 stop next edge");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule